// File: doc/BRIEF.md
# Interrupt Vector Dispatcher

This block turns interrupt and exception requests into an 8-bit type number and then reads the handler address for that type from a vector table in low memory. Three groups of requests feed it:

- **Instruction-side causes:** divide fault, conditional overflow trap, signed bounds check, breakpoint and software interrupt.
- **Non-maskable pin:** triggered by a rising edge.
- **Maskable request:** its type comes from an external bus and it is gated by an enable input.

When more than one request is active in the same cycle, a fixed priority picks the winner. The block acknowledges the winning type. It then reads the four table bytes for that entry through a byte-wide read port that returns data in the same cycle as the address. When the fourth byte arrives, it presents the new code segment and instruction pointer with a single-cycle done strobe.

A second fault can arrive while a fault is still being fetched. In that case the fetch in progress is dropped and the block dispatches the double-fault type instead. Apart from that case, requests that arrive during a fetch are dropped, with one exception: a rising edge on the non-maskable pin is latched and served once the fetch finishes. Stack handling and the return path belong to the core that uses this block.

Top module: `vec_dispatch`

## Requirements
- R1: The entry for type t starts at address TABLE_BASE + 4*t. Its four bytes are read in ascending address order, one per cycle. The first read takes place in the cycle in which ack_o is high.
- R2: ip_o = {byte1, byte0} and cs_o = {byte3, byte2}, so each 16-bit half is little-endian. done_o is high for exactly one cycle, four cycles after ack_o. cs_o and ip_o keep their values until the next completion.
- R3: A divide request dispatches type 0.
- R4: A rising edge on nmi_i dispatches type 2 whatever the value of if_i. An edge that arrives while a fetch is running, or that loses arbitration, is held and dispatched once the block is idle again.
- R5: A maskable request dispatches the type on intr_type_i when if_i is 1. When if_i is 0 it has no effect.
- R6: A breakpoint request dispatches type 3. A software request dispatches the type on swi_type_i.
- R7: An overflow-trap request dispatches type 4 when of_i is 1. When of_i is 0 it has no effect.
- R8: The bounds check treats the value and both limits as two's-complement numbers. It dispatches type 5 only when the value is below bnd_lo_i or above bnd_hi_i. A value equal to either limit has no effect.
- R9: Coincident requests are served in this order: divide, overflow trap, bounds, breakpoint, software, NMI, maskable.
- R10: While a fetch is running, new requests do not start a dispatch, with two exceptions: the NMI edge latch (R4) and promotion to double fault (R11).
- R11: While a type 0, 4 or 5 dispatch is being fetched, a new divide, overflow-trap or bounds fault restarts the fetch with type 8. Faults that arrive during a type 8 fetch, or during any non-fault fetch, are ignored.
- R12: During reset, ack_o, done_o and mem_req_o are low and cs_o and ip_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nmi_i | input | 1 | Non-maskable request, rising-edge sensitive |
| intr_i | input | 1 | Maskable request |
| if_i | input | 1 | Interrupt enable for the maskable request |
| intr_type_i | input | 8 | Type for the maskable request |
| swi_i | input | 1 | Software interrupt request |
| swi_type_i | input | 8 | Type for the software request |
| brk_i | input | 1 | Breakpoint request |
| into_i | input | 1 | Overflow-trap request |
| of_i | input | 1 | Overflow flag |
| div_i | input | 1 | Divide fault request |
| bnd_i | input | 1 | Bounds-check request |
| bnd_val_i | input | BND_W | Value under test, signed |
| bnd_lo_i | input | BND_W | Lower limit, signed |
| bnd_hi_i | input | BND_W | Upper limit, signed |
| mem_req_o | output | 1 | Table read strobe |
| mem_addr_o | output | ADDR_W | Table byte address |
| mem_data_i | input | 8 | Read data, valid in the same cycle as the address |
| ack_o | output | 1 | Accepted-type strobe |
| ack_type_o | output | 8 | Accepted type |
| done_o | output | 1 | Vector complete strobe |
| cs_o | output | 16 | Handler segment |
| ip_o | output | 16 | Handler offset |

## Verification
A source index that is wrong inside the arbiter shows up in the same cycle as a wrong ack_type_o, and the table address driven alongside it is also wrong. A lost or stuck fetch index shows up within four cycles, either as a missing or early done_o or as a non-consecutive address. A wrong byte order or a wrong shift position shows up only at done_o, where cs_o and ip_o are compared against table contents computed from the addresses. A fault-class flag that is set wrongly causes a type 8 acknowledge one cycle after the second request, or fails to cause one. A lost NMI latch shows up as the missing type 2 acknowledge in the cycle after done_o.

// File: rtl/vec_dispatch_pkg.sv
package vec_dispatch_pkg;
  localparam int TYPE_W      = 8;
  localparam int ENTRY_BYTES = 4;
  localparam int N_SRC       = 7;
  localparam int SRC_W       = $clog2(N_SRC);

  typedef logic [TYPE_W-1:0] vtype_t;

  localparam vtype_t T_DIV = 8'd0;
  localparam vtype_t T_NMI = 8'd2;
  localparam vtype_t T_BRK = 8'd3;
  localparam vtype_t T_OVF = 8'd4;
  localparam vtype_t T_BND = 8'd5;
  localparam vtype_t T_DBL = 8'd8;

  // index order is priority order, 0 highest
  typedef enum logic [SRC_W-1:0] {
    S_DIV  = 3'd0,
    S_OVF  = 3'd1,
    S_BND  = 3'd2,
    S_BRK  = 3'd3,
    S_SWI  = 3'd4,
    S_NMI  = 3'd5,
    S_INTR = 3'd6
  } src_e;
endpackage

// File: rtl/vec_bound_cmp.sv
module vec_bound_cmp #(
  parameter int W = 16
) (
  input  logic [W-1:0] val_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  output logic         out_o
);
  logic below, above;
  assign below = $signed(val_i) < $signed(lo_i);
  assign above = $signed(val_i) > $signed(hi_i);
  assign out_o = below | above;
endmodule

// File: rtl/vec_prio.sv
module vec_prio #(
  parameter int N = 7,
  parameter int W = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]        req_i,
  input  logic [N-1:0][W-1:0] type_i,
  output logic                valid_o,
  output logic [IW-1:0]       idx_o,
  output logic [W-1:0]        type_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    type_o  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        valid_o = 1'b1;
        idx_o   = IW'(i);
        type_o  = type_i[i];
      end
    end
  end
endmodule

// File: rtl/vec_fetch.sv
module vec_fetch
  import vec_dispatch_pkg::*;
#(
  parameter int                ADDR_W = 20,
  parameter logic [ADDR_W-1:0] BASE   = '0,
  localparam int               IDX_W  = $clog2(ENTRY_BYTES),
  localparam int               SH_W   = (ENTRY_BYTES - 1) * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  vtype_t            start_type_i,
  input  logic [7:0]        mem_data_i,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              done_o,
  output logic [15:0]       cs_o,
  output logic [15:0]       ip_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRY_BYTES - 1);

  logic             active_q;
  logic [IDX_W-1:0] idx_q;
  vtype_t           type_q;
  logic [SH_W-1:0]  shift_q;
  logic             done_q;
  logic [15:0]      cs_q, ip_q;

  assign busy_o     = active_q;
  assign mem_req_o  = active_q;
  assign mem_addr_o = BASE + ADDR_W'({type_q, {IDX_W{1'b0}}}) + ADDR_W'(idx_q);
  assign done_o     = done_q;
  assign cs_o       = cs_q;
  assign ip_o       = ip_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      type_q   <= '0;
      shift_q  <= '0;
      done_q   <= 1'b0;
      cs_q     <= '0;
      ip_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        active_q <= 1'b1;
        idx_q    <= '0;
        type_q   <= start_type_i;
      end else if (active_q) begin
        shift_q <= {mem_data_i, shift_q[SH_W-1:8]};
        idx_q   <= idx_q + 1'b1;
        if (idx_q == LAST) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
          ip_q     <= shift_q[15:0];
          cs_q     <= {mem_data_i, shift_q[SH_W-1:SH_W-8]};
        end
      end
    end
  end
endmodule

// File: rtl/vec_dispatch.sv
module vec_dispatch
  import vec_dispatch_pkg::*;
#(
  parameter int                ADDR_W     = 20,
  parameter int                BND_W      = 16,
  parameter logic [ADDR_W-1:0] TABLE_BASE = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              nmi_i,
  input  logic              intr_i,
  input  logic              if_i,
  input  logic [7:0]        intr_type_i,
  input  logic              swi_i,
  input  logic [7:0]        swi_type_i,
  input  logic              brk_i,
  input  logic              into_i,
  input  logic              of_i,
  input  logic              div_i,
  input  logic              bnd_i,
  input  logic [BND_W-1:0]  bnd_val_i,
  input  logic [BND_W-1:0]  bnd_lo_i,
  input  logic [BND_W-1:0]  bnd_hi_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_data_i,
  output logic              ack_o,
  output logic [7:0]        ack_type_o,
  output logic              done_o,
  output logic [15:0]       cs_o,
  output logic [15:0]       ip_o
);
  logic                           bnd_out;
  logic                           nmi_q, nmi_pend_q, nmi_req;
  logic [N_SRC-1:0]               src_req;
  logic [N_SRC-1:0][TYPE_W-1:0]   src_type;
  logic                           win_valid;
  logic [SRC_W-1:0]               win_idx;
  vtype_t                         win_type;
  logic                           busy, cur_fault_q, fault_now;
  logic                           accept, promote, start;
  vtype_t                         start_type;
  logic                           ack_q;
  vtype_t                         ack_type_q;

  vec_bound_cmp #(.W(BND_W)) u_bnd (
    .val_i (bnd_val_i),
    .lo_i  (bnd_lo_i),
    .hi_i  (bnd_hi_i),
    .out_o (bnd_out)
  );

  assign nmi_req = nmi_pend_q | (nmi_i & ~nmi_q);

  always_comb begin
    src_req          = '0;
    src_req[S_DIV]   = div_i;
    src_req[S_OVF]   = into_i & of_i;
    src_req[S_BND]   = bnd_i & bnd_out;
    src_req[S_BRK]   = brk_i;
    src_req[S_SWI]   = swi_i;
    src_req[S_NMI]   = nmi_req;
    src_req[S_INTR]  = intr_i & if_i;
    src_type         = '0;
    src_type[S_DIV]  = T_DIV;
    src_type[S_OVF]  = T_OVF;
    src_type[S_BND]  = T_BND;
    src_type[S_BRK]  = T_BRK;
    src_type[S_SWI]  = swi_type_i;
    src_type[S_NMI]  = T_NMI;
    src_type[S_INTR] = intr_type_i;
  end

  vec_prio #(.N(N_SRC), .W(TYPE_W)) u_prio (
    .req_i   (src_req),
    .type_i  (src_type),
    .valid_o (win_valid),
    .idx_o   (win_idx),
    .type_o  (win_type)
  );

  assign fault_now  = src_req[S_DIV] | src_req[S_OVF] | src_req[S_BND];
  assign accept     = ~busy & win_valid;
  assign promote    = busy & cur_fault_q & fault_now;
  assign start      = accept | promote;
  assign start_type = promote ? T_DBL : win_type;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_q       <= 1'b0;
      nmi_pend_q  <= 1'b0;
      cur_fault_q <= 1'b0;
      ack_q       <= 1'b0;
      ack_type_q  <= '0;
    end else begin
      nmi_q      <= nmi_i;
      nmi_pend_q <= nmi_req & ~(accept & (win_idx == S_NMI));
      if (promote) cur_fault_q <= 1'b0;
      else if (accept)
        cur_fault_q <= (win_idx == S_DIV) | (win_idx == S_OVF) | (win_idx == S_BND);
      ack_q <= start;
      if (start) ack_type_q <= start_type;
    end
  end

  vec_fetch #(.ADDR_W(ADDR_W), .BASE(TABLE_BASE)) u_fetch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .start_type_i (start_type),
    .mem_data_i   (mem_data_i),
    .busy_o       (busy),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .done_o       (done_o),
    .cs_o         (cs_o),
    .ip_o         (ip_o)
  );

  assign ack_o      = ack_q;
  assign ack_type_o = ack_type_q;
endmodule

// File: rtl/vec_dispatch_chk.sv
module vec_dispatch_chk #(
  parameter int                ADDR_W = 20,
  parameter logic [ADDR_W-1:0] BASE   = '0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ack_o,
  input logic [7:0]        ack_type_o,
  input logic              done_o,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [7:0]        mem_data_i,
  input logic [15:0]       cs_o,
  input logic [15:0]       ip_o
);
  a_r1_addr_at_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (mem_req_o && mem_addr_o == BASE + ADDR_W'({ack_type_o, 2'b00})));

  a_r1_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !ack_o) |-> ($past(mem_req_o) && mem_addr_o == $past(mem_addr_o) + 1'b1));

  a_r2_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r2_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_req_o);

  a_r2_ip_bytes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ip_o == {$past(mem_data_i, 3), $past(mem_data_i, 4)});

  a_r2_cs_bytes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cs_o == {$past(mem_data_i, 1), $past(mem_data_i, 2)});

  a_r11_midfetch_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && $past(mem_req_o)) |-> ack_type_o == 8'd8);
endmodule

bind vec_dispatch vec_dispatch_chk #(.ADDR_W(ADDR_W), .BASE(TABLE_BASE)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ack_o      (ack_o),
  .ack_type_o (ack_type_o),
  .done_o     (done_o),
  .mem_req_o  (mem_req_o),
  .mem_addr_o (mem_addr_o),
  .mem_data_i (mem_data_i),
  .cs_o       (cs_o),
  .ip_o       (ip_o)
);

// File: tb/vec_dispatch_bench.sv
module vec_dispatch_bench;
  localparam int AW = 20;
  localparam int BW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          nmi, intr, ifl, swi, brk, into, of, div, bnd;
  logic [7:0]    intr_type, swi_type;
  logic [BW-1:0] bval, blo, bhi;
  logic          mem_req, ack, done;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_data, ack_type;
  logic [15:0]   cs, ip;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] mb(input logic [AW-1:0] a);
    logic [AW-1:0] m;
    m = a * 37 + (a >> 5) + 20'h1b;
    return m[7:0];
  endfunction

  function automatic logic [15:0] exp_ip(input logic [7:0] t);
    return {mb(AW'({t, 2'b01})), mb(AW'({t, 2'b00}))};
  endfunction

  function automatic logic [15:0] exp_cs(input logic [7:0] t);
    return {mb(AW'({t, 2'b11})), mb(AW'({t, 2'b10}))};
  endfunction

  assign mem_data = mb(mem_addr);

  vec_dispatch u_vec_dispatch (
    .clk_i (clk), .rst_ni (rst_n), .nmi_i (nmi), .intr_i (intr), .if_i (ifl),
    .intr_type_i (intr_type), .swi_i (swi), .swi_type_i (swi_type), .brk_i (brk),
    .into_i (into), .of_i (of), .div_i (div), .bnd_i (bnd), .bnd_val_i (bval),
    .bnd_lo_i (blo), .bnd_hi_i (bhi), .mem_req_o (mem_req), .mem_addr_o (mem_addr),
    .mem_data_i (mem_data), .ack_o (ack), .ack_type_o (ack_type), .done_o (done),
    .cs_o (cs), .ip_o (ip)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_req();
    nmi = 0; intr = 0; swi = 0; brk = 0; into = 0; of = 0; div = 0; bnd = 0;
  endtask

  // called at the negedge right after the request edge
  task automatic expect_ack(input string req, input logic [7:0] t);
    check(ack === 1'b1, req, 32'(ack), 32'd1);
    check(ack_type === t, req, 32'(ack_type), 32'(t));
  endtask

  task automatic expect_done(input string req, input logic [7:0] t);
    repeat (3) begin
      @(negedge clk);
      check(done === 1'b0, req, 32'(done), 32'd0);
    end
    @(negedge clk);
    check(done === 1'b1, req, 32'(done), 32'd1);
    check(ip === exp_ip(t), req, 32'(ip), 32'(exp_ip(t)));
    check(cs === exp_cs(t), req, 32'(cs), 32'(exp_cs(t)));
  endtask

  task automatic expect_quiet(input string req, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      check(ack === 1'b0 && mem_req === 1'b0, req, 32'({ack, mem_req}), 32'd0);
      @(negedge clk);
    end
  endtask

  task automatic pulse_and_dispatch(input string req, input logic [7:0] t);
    @(negedge clk);
    clear_req();
    expect_ack(req, t);
    expect_done(req, t);
    @(negedge clk);
    check(done === 1'b0, {req, " done one cycle"}, 32'(done), 32'd0);
  endtask

  task automatic t_reset();
    check(ack === 0 && done === 0 && mem_req === 0, "R12", 32'({ack, done, mem_req}), 32'd0);
    check(cs === 0 && ip === 0, "R12", 32'({cs, ip}), 32'd0);
  endtask

  task automatic t_div();
    div = 1;
    pulse_and_dispatch("R3 R1 R2", 8'd0);
  endtask

  task automatic t_nmi_masked_if();
    ifl = 0; nmi = 1;
    pulse_and_dispatch("R4", 8'd2);
  endtask

  task automatic t_intr();
    ifl = 0; intr = 1; intr_type = 8'h47;
    @(negedge clk); clear_req();
    expect_quiet("R5 masked", 3);
    ifl = 1; intr = 1; intr_type = 8'hA9;
    pulse_and_dispatch("R5", 8'hA9);
    ifl = 0;
  endtask

  task automatic t_brk_swi();
    brk = 1;
    pulse_and_dispatch("R6 brk", 8'd3);
    swi = 1; swi_type = 8'hFF;
    pulse_and_dispatch("R6 swi", 8'hFF);
  endtask

  task automatic t_into();
    into = 1; of = 0;
    @(negedge clk); clear_req();
    expect_quiet("R7 of clear", 3);
    into = 1; of = 1;
    pulse_and_dispatch("R7", 8'd4);
  endtask

  task automatic t_bounds();
    blo = 16'hFFFB; bhi = 16'd100;
    bval = 16'hFFFB; bnd = 1;
    @(negedge clk); clear_req();
    expect_quiet("R8 at low limit", 2);
    bval = 16'd100; bnd = 1;
    @(negedge clk); clear_req();
    expect_quiet("R8 at high limit", 2);
    bval = 16'hFFFA; bnd = 1;
    pulse_and_dispatch("R8 below", 8'd5);
    bval = 16'd101; bnd = 1;
    pulse_and_dispatch("R8 above", 8'd5);
  endtask

  task automatic t_priority();
    div = 1; into = 1; of = 1; bval = 16'd500; bnd = 1; brk = 1;
    pulse_and_dispatch("R9 div first", 8'd0);
    into = 1; of = 1; bnd = 1; brk = 1;
    pulse_and_dispatch("R9 ovf over bnd", 8'd4);
    bnd = 1; brk = 1; swi = 1; swi_type = 8'h21;
    pulse_and_dispatch("R9 bnd over brk", 8'd5);
    brk = 1; swi = 1;
    pulse_and_dispatch("R9 brk over swi", 8'd3);
    // swi beats nmi and intr; nmi edge held, then served (R4)
    swi = 1; swi_type = 8'h30; nmi = 1; intr = 1; ifl = 1; intr_type = 8'h77;
    @(negedge clk);
    clear_req();
    expect_ack("R9 swi over nmi", 8'h30);
    expect_done("R9 swi over nmi", 8'h30);
    @(negedge clk);
    expect_ack("R4 held edge", 8'd2);
    expect_done("R4 held edge", 8'd2);
    @(negedge clk);
    nmi = 1; intr = 1;
    pulse_and_dispatch("R9 nmi over intr", 8'd2);
    ifl = 0;
  endtask

  task automatic t_busy_ignore();
    brk = 1;
    @(negedge clk);
    clear_req();
    expect_ack("R10", 8'd3);
    swi = 1; swi_type = 8'h55; intr = 1; ifl = 1; intr_type = 8'h66; div = 1;
    @(negedge clk);
    clear_req(); ifl = 0;
    check(ack === 1'b0, "R10 no ack mid fetch", 32'(ack), 32'd0);
    repeat (2) @(negedge clk);
    @(negedge clk);
    check(done === 1'b1 && ip === exp_ip(8'd3), "R10 brk completes", 32'(ip), 32'(exp_ip(8'd3)));
    @(negedge clk);
    expect_quiet("R10 dropped", 3);
  endtask

  task automatic t_double();
    bval = 16'd200; bnd = 1;
    @(negedge clk);
    clear_req();
    expect_ack("R11 first fault", 8'd5);
    div = 1;
    @(negedge clk);
    clear_req();
    expect_ack("R11 promote", 8'd8);
    into = 1; of = 1;
    @(negedge clk);
    clear_req();
    check(ack === 1'b0, "R11 no promote from type 8", 32'(ack), 32'd0);
    repeat (2) @(negedge clk);
    @(negedge clk);
    check(done === 1'b1, "R11 done", 32'(done), 32'd1);
    check(ip === exp_ip(8'd8) && cs === exp_cs(8'd8), "R11 vector", 32'({cs, ip}),
          32'({exp_cs(8'd8), exp_ip(8'd8)}));
    @(negedge clk);
    expect_quiet("R11 after", 2);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    clear_req(); ifl = 0; intr_type = 0; swi_type = 0; bval = 0; blo = 0; bhi = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_div();
    t_nmi_masked_if();
    t_intr();
    t_brk_swi();
    t_into();
    t_bounds();
    t_priority();
    t_busy_ignore();
    t_double();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule